// File: doc/BRIEF.md
# I2C Bus Status and Interrupt Flag Unit

This block watches the two wires of an I2C bus and the event strobes of a byte-level master/slave engine, and turns them into one 8-bit read-only status word plus a level interrupt request. It synchronises SCL and SDA, finds start and stop conditions, keeps a bus-busy bit, and shifts in the first byte after each start. That byte is compared against a programmable 7-bit own address and against the general-call address.

Five causes feed one interrupt flag that software can clear. The causes are: an own-address hit, a general-call hit, a byte finished in master mode (counted even when arbitration was lost), a byte finished while selected as a slave, and a stop seen while selected as a slave. Software either enables the request output or polls bit 5 of the status word. The flag can be written. Writing 0 clears it, and writing 1 sets it.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset the status word is 8'h00 and `irq` is 0. Status bit order is: bit7 general call, bit6 stop seen, bit5 flag, bit4 transmit mode, bit3 busy, bit2 arbitration lost, bit1 acknowledge level, bit0 selected slave.
- R2: A start condition (SDA falls while SCL is high) sets bit3 and clears bits 7, 6, 2 and 0. A stop condition (SDA rises while SCL is high) clears bit3.
- R3: In slave mode (`master_mode`=0) with `ack_en`=1, an address byte whose upper 7 bits equal `own_addr` sets bit0 and bit5, and bit4 takes the byte's LSB (R/W). No hit occurs when `ack_en`=0 or `master_mode`=1.
- R4: In slave mode with `ack_en`=1, the address byte 8'h00 sets bit7 and bit5. The byte 8'h01 does not.
- R5: `byte_done` in master mode sets bit5. A pulse on `arb_lost` sets bit2. When both pulse together, both bits set. Bit2 clears at the next start.
- R6: `byte_done` in slave mode sets bit5 only while bit0 is 1.
- R7: A stop while bit0 is 1 sets bit6 and bit5 and clears bit0. A stop while bit0 is 0 leaves bit5 unchanged.
- R8: Bit1 holds the SDA level sampled on the ninth SCL rising edge of each byte. A level of 0 means acknowledged.
- R9: A write with `flag_wr`=1 loads `flag_wdata` into bit5. When a hardware cause fires in the same cycle, the flag is set regardless of the written value.
- R10: `irq` equals bit5 AND `irq_en` AND `glob_en`.
- R11: In master mode, bit4 follows the `mst_tx` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| own_addr | input | 7 | Programmed own slave address |
| ack_en | input | 1 | Acknowledge enable; permits address hits |
| master_mode | input | 1 | 1 = engine is bus master, 0 = slave |
| mst_tx | input | 1 | Transmit direction while master |
| byte_done | input | 1 | One-cycle pulse: data byte finished |
| arb_lost | input | 1 | One-cycle pulse: arbitration lost |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Value written to the flag |
| irq_en | input | 1 | I2C interrupt enable |
| glob_en | input | 1 | Global interrupt enable |
| status | output | 8 | Status word |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situations to reach from the ports are a hardware set and a software clear of the flag landing in the same clock, and a stop arriving while the unit is a selected slave. The stimulus handles the stop case by bit-banging whole transactions onto SCL and SDA. Random address bytes are biased toward the own address, the general-call byte and its read variant, with random acknowledge enables, so that selection and non-selection both occur before each stop. A directed step drives `flag_wr` with data 0 in the same cycle as a master `byte_done`. Another directed step pulses arbitration loss together with byte completion.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int AW     = 7;
  localparam int BYTE_W = AW + 1;

  localparam int B_GC    = 7;
  localparam int B_STOP  = 6;
  localparam int B_FLAG  = 5;
  localparam int B_TX    = 4;
  localparam int B_BUSY  = 3;
  localparam int B_BLOST = 2;
  localparam int B_ACK   = 1;
  localparam int B_SLV   = 0;

  function automatic logic addr_is_own(input logic [BYTE_W-1:0] b,
                                       input logic [AW-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  function automatic logic addr_is_gc(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '1;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
endmodule

// File: rtl/i2c_addr_cap.sv
module i2c_addr_cap #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            scl_rise,
  input  logic            sda_s,
  output logic            addr_done,
  output logic [BITS-1:0] addr_byte,
  output logic            ninth
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);
  localparam logic [CW-1:0] PRE  = CW'(BITS - 1);

  logic [CW-1:0]   cnt;
  logic [BITS-2:0] sh;
  logic            in_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sh      <= '0;
      in_addr <= 1'b0;
    end else if (start_det) begin
      cnt     <= '0;
      in_addr <= 1'b1;
    end else if (stop_det) begin
      cnt     <= '0;
      in_addr <= 1'b0;
    end else if (scl_rise) begin
      if (cnt == LAST) begin
        cnt     <= '0;
        in_addr <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[BITS-3:0], sda_s};
      end
    end
  end

  assign addr_done = scl_rise & in_addr & (cnt == PRE);
  assign addr_byte = {sh, sda_s};
  assign ninth     = scl_rise & (cnt == LAST);
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [AW-1:0] own_addr,
  input  logic          ack_en,
  input  logic          master_mode,
  input  logic          mst_tx,
  input  logic          byte_done,
  input  logic          arb_lost,
  input  logic          flag_wr,
  input  logic          flag_wdata,
  input  logic          irq_en,
  input  logic          glob_en,
  output logic [7:0]    status,
  output logic          irq
);
  logic [1:0] lines_s;
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise;
  logic addr_done, ninth;
  logic [BYTE_W-1:0] addr_byte;

  i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise));

  i2c_addr_cap #(.BITS(BYTE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .sda_s(sda_s), .addr_done(addr_done),
    .addr_byte(addr_byte), .ninth(ninth));

  logic gc_q, stop_q, flag_q, busy_q, blost_q, ack_q, slv_q, rw_q;

  // Named cause wires, also observed by the checker
  logic slave_ok, own_hit, gc_hit, m_done, s_done, stop_slv, set_any;
  assign slave_ok = addr_done & ~master_mode & ack_en;
  assign own_hit  = slave_ok & addr_is_own(addr_byte, own_addr);
  assign gc_hit   = slave_ok & addr_is_gc(addr_byte);
  assign m_done   = byte_done & master_mode;
  assign s_done   = byte_done & ~master_mode & slv_q;
  assign stop_slv = stop_det & slv_q;
  assign set_any  = own_hit | gc_hit | m_done | s_done | stop_slv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gc_q <= 1'b0; stop_q <= 1'b0; busy_q <= 1'b0; blost_q <= 1'b0;
      ack_q <= 1'b0; slv_q <= 1'b0; rw_q <= 1'b0;
    end else begin
      if (start_det) begin
        busy_q <= 1'b1; gc_q <= 1'b0; stop_q <= 1'b0;
        blost_q <= 1'b0; slv_q <= 1'b0; rw_q <= 1'b0;
      end else if (stop_det) begin
        busy_q <= 1'b0; slv_q <= 1'b0; rw_q <= 1'b0;
        if (slv_q) stop_q <= 1'b1;
      end else begin
        if (own_hit) begin
          slv_q <= 1'b1;
          rw_q  <= addr_byte[0];
        end
        if (gc_hit) gc_q <= 1'b1;
      end
      if (arb_lost && !start_det) blost_q <= 1'b1;
      if (ninth) ack_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_any) flag_q <= 1'b1;
    else if (flag_wr) flag_q <= flag_wdata;
  end

  logic tx_bit;
  assign tx_bit = master_mode ? mst_tx : rw_q;

  always_comb begin
    status          = '0;
    status[B_GC]    = gc_q;
    status[B_STOP]  = stop_q;
    status[B_FLAG]  = flag_q;
    status[B_TX]    = tx_bit;
    status[B_BUSY]  = busy_q;
    status[B_BLOST] = blost_q;
    status[B_ACK]   = ack_q;
    status[B_SLV]   = slv_q;
  end

  assign irq = flag_q & irq_en & glob_en;
endmodule

// File: rtl/i2c_stat_irq_chk.sv
module i2c_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       irq,
  input logic       flag_wr,
  input logic       flag_wdata,
  input logic       byte_done,
  input logic       master_mode,
  input logic       start_det,
  input logic       stop_det,
  input logic       own_hit,
  input logic       gc_hit,
  input logic       set_any
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> status == 8'h00);

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> status[3] && !status[0] && !status[6]);

  a_r2_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !status[3] && !status[0]);

  a_r3_own_select: assert property (@(posedge clk) disable iff (!rst_n)
    own_hit |=> status[0] && status[5]);

  a_r4_gc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |=> status[7] && status[5]);

  a_r5_master_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && master_mode |=> status[5]);

  a_r7_stop_selected: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && status[0] |=> status[6] && status[5]);

  a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr && !flag_wdata && !set_any |=> !status[5]);

  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[5]);
endmodule

bind i2c_stat_irq i2c_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .irq(irq),
  .flag_wr(flag_wr), .flag_wdata(flag_wdata), .byte_done(byte_done),
  .master_mode(master_mode), .start_det(start_det), .stop_det(stop_det),
  .own_hit(own_hit), .gc_hit(gc_hit), .set_any(set_any));

// File: tb/i2c_stat_irq_tb_top.sv
module i2c_stat_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic [6:0] own = 7'h2A;
  logic ack_en = 1'b1, master_mode = 1'b0, mst_tx = 1'b0;
  logic byte_done = 1'b0, arb_lost = 1'b0;
  logic flag_wr = 1'b0, flag_wdata = 1'b0;
  logic irq_en = 1'b0, glob_en = 1'b0;
  logic [7:0] status;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  logic e_gc, e_stop, e_flag, e_busy, e_blost, e_ack, e_slv, e_rw;

  always #4 clk = ~clk;

  i2c_stat_irq dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .own_addr(own),
    .ack_en(ack_en), .master_mode(master_mode), .mst_tx(mst_tx),
    .byte_done(byte_done), .arb_lost(arb_lost), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .glob_en(glob_en),
    .status(status), .irq(irq));

  function automatic logic [7:0] exp_word();
    logic tx;
    tx = master_mode ? mst_tx : e_rw;
    return {e_gc, e_stop, e_flag, tx, e_busy, e_blost, e_ack, e_slv};
  endfunction

  function automatic logic hits_own(input logic [7:0] b, input logic [6:0] o);
    return (b >> 1) == {1'b0, o};
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 1'b1; sda = 1'b1; wait_n(4);
    sda = 1'b0; wait_n(4);
    scl = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda = 1'b0; wait_n(4);
    scl = 1'b1; wait_n(4);
    sda = 1'b1; wait_n(4);
  endtask

  task automatic bus_bit(input logic b);
    scl = 1'b0; sda = b; wait_n(4);
    scl = 1'b1; wait_n(4);
    scl = 1'b0; wait_n(4);
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic ackv);
    for (int k = 7; k >= 0; k--) bus_bit(b[k]);
    bus_bit(ackv);
  endtask

  task automatic pulse_done(input logic lost);
    byte_done = 1'b1; arb_lost = lost;
    wait_n(1);
    byte_done = 1'b0; arb_lost = 1'b0;
  endtask

  task automatic sw_write(input logic v);
    flag_wr = 1'b1; flag_wdata = v;
    wait_n(1);
    flag_wr = 1'b0;
  endtask

  task automatic model_start();
    e_busy = 1; e_gc = 0; e_stop = 0; e_blost = 0; e_slv = 0; e_rw = 0;
  endtask

  task automatic model_stop();
    e_busy = 0; e_rw = 0;
    if (e_slv) begin e_stop = 1; e_flag = 1; end
    e_slv = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic ackv;
    int kind;
    void'($urandom(32'd4711));
    e_gc = 0; e_stop = 0; e_flag = 0; e_busy = 0; e_blost = 0;
    e_ack = 0; e_slv = 0; e_rw = 0;
    wait_n(3);
    chk8("R1 reset", status, 8'h00);
    chk8("R1 irq reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_n(6);
    chk8("R1 idle", status, exp_word());

    // Random slave transactions
    for (int it = 0; it < 40; it++) begin
      own = 7'($urandom_range(1, 127));
      ack_en = ($urandom_range(0, 3) != 0);
      kind = $urandom_range(0, 3);
      case (kind)
        0: b = {own, 1'($urandom_range(0, 1))};
        1: b = 8'h00;
        2: b = 8'h01;
        default: b = 8'($urandom_range(0, 255));
      endcase
      ackv = 1'($urandom_range(0, 1));
      bus_start();
      model_start();
      chk8("R2 start", status, exp_word());
      bus_byte(b, ackv);
      e_ack = ackv;
      if (ack_en && hits_own(b, own)) begin e_slv = 1; e_rw = b[0]; e_flag = 1; end
      if (ack_en && b == 8'h00) begin e_gc = 1; e_flag = 1; end
      chk8(kind == 1 || kind == 2 ? "R4 gc address" : "R3 own address", status, exp_word());
      chk8("R8 ack level", {7'd0, status[1]}, {7'd0, ackv});
      if ($urandom_range(0, 1) == 1) begin
        sw_write(1'b0); e_flag = 0;
        chk8("R9 clear", status, exp_word());
        pulse_done(1'b0);
        if (e_slv) e_flag = 1;
        chk8("R6 slave byte", status, exp_word());
      end
      irq_en = 1'($urandom_range(0, 1));
      glob_en = 1'($urandom_range(0, 1));
      wait_n(1);
      chk8("R10 irq", {7'd0, irq}, {7'd0, e_flag & irq_en & glob_en});
      sw_write(1'b0); e_flag = 0;
      bus_stop();
      model_stop();
      chk8("R7 stop", status, exp_word());
      sw_write(1'b0); e_flag = 0;
      chk8("R9 clear after stop", status, exp_word());
    end

    // Software set
    sw_write(1'b1); e_flag = 1;
    chk8("R9 write one", status, exp_word());
    sw_write(1'b0); e_flag = 0;

    // Master mode: own address on bus must not select
    master_mode = 1'b1; mst_tx = 1'b1; ack_en = 1'b1; own = 7'h35;
    bus_start(); model_start();
    bus_byte({7'h35, 1'b0}, 1'b0); e_ack = 0;
    chk8("R3 no hit in master / R11 tx", status, exp_word());
    pulse_done(1'b1); e_blost = 1; e_flag = 1;
    chk8("R5 arb lost byte", status, exp_word());
    sw_write(1'b0); e_flag = 0;
    // Same cycle: hardware set beats software clear
    byte_done = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
    wait_n(1);
    byte_done = 1'b0; flag_wr = 1'b0; e_flag = 1;
    chk8("R9 set wins", status, exp_word());
    mst_tx = 1'b0;
    wait_n(1);
    chk8("R11 tx follows", status, exp_word());
    sw_write(1'b0); e_flag = 0;
    bus_stop(); model_stop();
    chk8("R7 stop unselected", status, exp_word());
    bus_start(); model_start();
    chk8("R5 blost cleared", status, exp_word());
    bus_stop(); model_stop();

    // Slave unselected: byte_done ignored
    master_mode = 1'b0;
    pulse_done(1'b0);
    chk8("R6 unselected byte", status, exp_word());
    // ack_en low blocks own match
    ack_en = 1'b0; own = 7'h11;
    bus_start(); model_start();
    bus_byte({7'h11, 1'b1}, 1'b1); e_ack = 1;
    chk8("R3 ack_en low", status, exp_word());
    bus_stop(); model_stop();
    chk8("R7 final stop", status, exp_word());

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule